// File: doc/BRIEF.md
# Nine-bit load/shift register with two clock sources

This block holds a nine-bit word, sized for one data byte plus its parity bit. A mode input decides what happens on each update. In load mode all nine parallel inputs are copied into the register. In shift mode the word moves one place toward the top bit: a serial input bit enters at bit 0, and the top bit is the serial output. All nine bits are always visible on the parallel output. Used this way, a byte and its parity can be written in parallel and sent out serially, or received serially and read in parallel.

Updates can come from either of two clock-source inputs. Both sources are sampled by one system clock. A low-to-high change seen on either source produces one update in that system-clock cycle. A change seen on both sources in the same cycle still produces only one update. An active-high master clear empties the register at once, without waiting for a clock. While the clear is held, the register ignores both sources.

Top module: `parity_shift_reg`

## Requirements
- R1: Raising `clr` forces all nine bits of `q` to zero at once, with no system-clock edge needed.
- R2: While `clr` is high, rises on `tick_a` or `tick_b` have no effect and `q` stays at zero.
- R3: An update happens only at the system-clock edge where a tick input is first sampled high after being sampled low. A tick held high gives no further updates, and a falling tick gives none.
- R4: Load mode is `mode_shift` = 0. In load mode an update copies `par_in[i]` into bit i for every i from 0 to 8.
- R5: Shift mode is `mode_shift` = 1. In shift mode an update puts `ser_in` into bit 0 and the old bit i-1 into bit i for i from 1 to 8. In this mode `par_in` is ignored.
- R6: When both tick inputs rise in the same system-clock cycle, exactly one update happens (for example, a shift moves the word by one place, not two).
- R7: A tick input that is already high when `clr` is released does not count as a rise. The first update after release needs a fresh low-to-high change.
- R8: After nine shifts the register holds only serial bits: the first bit shifted in appears on `q[8]`, which serves as the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the tick inputs and updates the register |
| clr | input | 1 | Asynchronous master clear, active high |
| tick_a | input | 1 | First clock source; its rising change requests an update |
| tick_b | input | 1 | Second clock source; its rising change requests an update |
| mode_shift | input | 1 | 1 selects shift, 0 selects load |
| ser_in | input | 1 | Serial bit that enters bit 0 on a shift |
| par_in | input | 9 | Parallel word copied in on a load |
| q | output | 9 | Current register contents; q[8] is the serial output |

## Verification
Two events can fall in the same system-clock cycle: a rise on `tick_a` and a rise on `tick_b`. Both are asked to update the register. The bench drives both ticks high on the same falling clock edge, in shift mode and in load mode. It then compares `q` with a model that applies exactly one update. A double shift would leave a result that differs from the model in bit 1 or above. The clear and a tick rise can also coincide: in that case the tick must lose, and `q` must read zero.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int unsigned PSR_WIDTH_DEF = 9;
  localparam int unsigned PSR_SRCS_DEF  = 2;

  typedef enum logic {
    PSR_MODE_LOAD  = 1'b0,
    PSR_MODE_SHIFT = 1'b1
  } psr_mode_e;

endpackage

// File: rtl/psr_edge_detect.sv
module psr_edge_detect #(
  parameter int unsigned SRCS = psr_pkg::PSR_SRCS_DEF
) (
  input  logic            clk,
  input  logic            clr,
  input  logic [SRCS-1:0] tick,
  output logic [SRCS-1:0] rise,
  output logic            fire
);

  function automatic logic is_rise(input logic now_v, input logic before_v);
    return now_v & ~before_v;
  endfunction

  for (genvar g = 0; g < SRCS; g++) begin : g_lane
    logic last_r;

    // Reset value 1: a level already high when clear is released is not a rise.
    always_ff @(posedge clk or posedge clr) begin
      if (clr) last_r <= 1'b1;
      else     last_r <= tick[g];
    end

    assign rise[g] = is_rise(tick[g], last_r);

    assert_single_pulse_R3: assert property (
      @(posedge clk) disable iff (clr) rise[g] |=> !rise[g]);
  end

  assign fire = |rise;

endmodule

// File: rtl/psr_next_state.sv
module psr_next_state #(
  parameter int unsigned WIDTH = psr_pkg::PSR_WIDTH_DEF
) (
  input  psr_pkg::psr_mode_e mode,
  input  logic               ser_in,
  input  logic [WIDTH-1:0]   par_in,
  input  logic [WIDTH-1:0]   cur,
  output logic [WIDTH-1:0]   nxt
);

  localparam int unsigned TOP = WIDTH - 1;

  function automatic logic [WIDTH-1:0] shift_up(input logic [WIDTH-1:0] w,
                                                input logic             s);
    return {w[TOP-1:0], s};
  endfunction

  function automatic logic [WIDTH-1:0] load_word(input logic [WIDTH-1:0] p);
    return p;
  endfunction

  always_comb begin
    unique case (mode)
      psr_pkg::PSR_MODE_SHIFT: nxt = shift_up(cur, ser_in);
      default:                 nxt = load_word(par_in);
    endcase
  end

endmodule

// File: rtl/psr_store.sv
module psr_store #(
  parameter int unsigned WIDTH = psr_pkg::PSR_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_en,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)          q_r <= '0;
    else if (load_en) q_r <= nxt;
  end

  assign q = q_r;

  assert_hold_idle_R3: assert property (
    @(posedge clk) disable iff (clr) !load_en |=> $stable(q_r));

  always @(posedge clk) begin
    if (clr) begin
      assert_clear_hold_R2: assert (q_r == '0);
    end
  end

endmodule

// File: rtl/parity_shift_reg.sv
module parity_shift_reg #(
  parameter int unsigned WIDTH = psr_pkg::PSR_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             mode_shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);

  localparam int unsigned SRCS = 2;
  localparam int unsigned TOP  = WIDTH - 1;

  logic [SRCS-1:0]    tick_vec;
  logic [SRCS-1:0]    rise;
  logic               fire;
  logic [WIDTH-1:0]   nxt;
  psr_pkg::psr_mode_e mode;

  assign tick_vec = {tick_b, tick_a};
  assign mode     = psr_pkg::psr_mode_e'(mode_shift);

  psr_edge_detect #(.SRCS(SRCS)) u_edges (
    .clk  (clk),
    .clr  (clr),
    .tick (tick_vec),
    .rise (rise),
    .fire (fire)
  );

  psr_next_state #(.WIDTH(WIDTH)) u_next (
    .mode   (mode),
    .ser_in (ser_in),
    .par_in (par_in),
    .cur    (q),
    .nxt    (nxt)
  );

  psr_store #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .clr     (clr),
    .load_en (fire),
    .nxt     (nxt),
    .q       (q)
  );

  assert_load_copy_R4: assert property (
    @(posedge clk) disable iff (clr)
    (fire && !mode_shift) |=> (q == $past(par_in)));

  assert_shift_step_R5: assert property (
    @(posedge clk) disable iff (clr)
    (fire && mode_shift) |=>
      (q[0] == $past(ser_in)) && (q[TOP:1] == $past(q[TOP-1:0])));

  assert_dual_single_R6: assert property (
    @(posedge clk) disable iff (clr)
    ((&rise) && mode_shift) |=> (q[TOP:1] == $past(q[TOP-1:0])));

endmodule

// File: tb/test_parity_shift_reg.sv
`timescale 1ns/1ps
module test_parity_shift_reg;

  localparam int W = 9;
  localparam int NV = 14;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic         tick_a = 1'b0;
  logic         tick_b = 1'b0;
  logic         mode_shift = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  parity_shift_reg i_parity_shift_reg (
    .clk(clk), .clr(clr), .tick_a(tick_a), .tick_b(tick_b),
    .mode_shift(mode_shift), .ser_in(ser_in), .par_in(par_in), .q(q)
  );

  // fields: use_a, use_b, shift, serial bit, parallel word
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 9'h1A5},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h1FF},
    {1'b0, 1'b1, 1'b1, 1'b0, 9'h000},
    {1'b1, 1'b1, 1'b1, 1'b1, 9'h0F0},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h000},
    {1'b0, 1'b1, 1'b1, 1'b0, 9'h1FF},
    {1'b1, 1'b1, 1'b1, 1'b0, 9'h000},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h055},
    {1'b0, 1'b1, 1'b1, 1'b0, 9'h000},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h000},
    {1'b0, 1'b1, 1'b0, 1'b1, 9'h0F0},
    {1'b1, 1'b1, 1'b1, 1'b1, 9'h000},
    {1'b1, 1'b1, 1'b0, 1'b0, 9'h155},
    {1'b0, 1'b1, 1'b1, 1'b0, 9'h1FF}
  };

  // Bench model: builds the next word bit by bit.
  function automatic logic [W-1:0] expect_next(input logic [W-1:0] cur,
      input logic sh, input logic s, input logic [W-1:0] p);
    logic [W-1:0] r;
    if (!sh) return p;
    r[0] = s;
    for (int i = 1; i < W; i++) r[i] = cur[i-1];
    return r;
  endfunction

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp,
                       input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%h expected %h", tag, got, exp);
    end
  endtask

  // Raise the chosen ticks at a falling edge, check after the next rising edge,
  // then drop them and let one more cycle pass so the next rise is fresh.
  task automatic pulse(input logic a, input logic b, input logic sh,
                       input logic s, input logic [W-1:0] p, input string tag);
    @(negedge clk);
    mode_shift = sh; ser_in = s; par_in = p;
    tick_a = a; tick_b = b;
    model = expect_next(model, sh, s, p);
    @(negedge clk);
    check(q, model, tag);
    tick_a = 1'b0; tick_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: q=%h expected completion", q);
    finish_run();
  end

  initial begin
    // R1: clear from power-up
    #1 clr = 1'b1;
    #2 check(q, '0, "R1 clear at start");
    repeat (2) @(negedge clk);
    clr = 1'b0;
    model = '0;
    @(negedge clk);

    // Table: a load, nine shifts, then mixed loads and shifts (R4 R5 R6)
    for (int k = 0; k < NV; k++) begin
      logic [12:0] v;
      v = VEC[k];
      pulse(v[12], v[11], v[10], v[9], v[8:0],
            (v[12] && v[11]) ? "R6 both ticks" : (v[10] ? "R5 shift" : "R4 load"));
      if (k == 9) check({8'h00, q[8]}, 9'h001, "R8 first serial bit on q[8]");
    end

    // R3: held tick gives one update, falling tick gives none
    @(negedge clk);
    mode_shift = 1'b0; par_in = 9'h111; tick_a = 1'b1;
    model = 9'h111;
    @(negedge clk);
    check(q, model, "R3 first rise loads");
    par_in = 9'h0EE;
    repeat (3) @(negedge clk);
    check(q, model, "R3 held tick no reload");
    tick_a = 1'b0;
    repeat (2) @(negedge clk);
    check(q, model, "R3 falling tick no update");

    // R6: both ticks, shift, one step only
    pulse(1'b1, 1'b1, 1'b1, 1'b1, 9'h000, "R6 single shift on dual rise");

    // R1 mid-sequence: asynchronous clear between clock edges
    @(negedge clk);
    #1 clr = 1'b1;
    #1 check(q, '0, "R1 async clear mid-cycle");
    model = '0;

    // R2: ticks while clear held
    @(negedge clk);
    mode_shift = 1'b0; par_in = 9'h1FF; tick_a = 1'b1; tick_b = 1'b1;
    repeat (2) @(negedge clk);
    check(q, '0, "R2 ticks ignored during clear");
    tick_b = 1'b0;

    // R7: tick_a still high at release is not a rise
    @(negedge clk);
    clr = 1'b0;
    repeat (3) @(negedge clk);
    check(q, '0, "R7 level at release ignored");
    tick_a = 1'b0;
    @(negedge clk);
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 9'h0AA, "R7 fresh rise after release");

    // R5: parallel input ignored while shifting
    pulse(1'b0, 1'b1, 1'b1, 1'b0, 9'h1FF, "R5 shift ignores par_in");

    finish_run();
  end

endmodule